// File: doc/BRIEF.md
# Isolated Digital I/O Port Register Block

This block is the register front end of a digital I/O card with sixteen output channels and sixteen input channels. A host reaches it over a small 8-bit port bus: a 3-bit offset, a read strobe, a write strobe and a byte of data in each direction. Two write-only byte registers drive the output lines. Two read-only byte registers return the input levels after they pass through a two-flop synchronizer.

The block raises one interrupt when any input line changes level, rising or falling. Software controls the interrupt only through the side effects of bus accesses, never through data values. A read of the control offset turns the interrupt on. A write to the control offset turns it off and discards any pending event. A write of any value to the low input offset acknowledges a pending event.

The bus strobes are assumed to be one-cycle pulses, synchronous to `clk`. Read data is combinational while the read strobe is high.

Top module: `iso_dio_regs`

## Requirements
- R1: After a synchronous active-low reset, all sixteen output lines are 0 and `irq` is low.
- R2: A write to offset 0 loads `bus_wdata` onto `out_lines[7:0]`, and a write to offset 4 loads it onto `out_lines[15:8]`. Each write leaves the other byte unchanged, and the new value is visible after the clock edge that samples the strobe.
- R3: A read of offset 1 returns `in_lines[7:0]` and a read of offset 5 returns `in_lines[15:8]`. Both values pass through two synchronizer flops, so a level change is readable from the second rising edge after it.
- R4: A read of offset 2 enables the interrupt. A write to offset 2 disables it and clears any pending event. If both strobes hit offset 2 in the same cycle, the write wins.
- R5: While the interrupt is enabled, a change of any input line in either direction sets a pending flag. `irq` rises after the third rising edge following the change and stays high until the event is cleared.
- R6: A write of any data value to offset 1 clears a pending event and drops `irq` after that edge.
- R7: Input changes that settle while the interrupt is disabled are not recorded, so a later enable does not raise `irq` for them.
- R8: Writes to offsets 3, 5, 6 and 7 and reads of offsets 0, 3 and 4 change neither the output lines nor `irq`.
- R9: If a clear write to offset 1 arrives in the same cycle as a newly detected input change, the event stays pending and `irq` stays high.
- R10: `bus_rdata` is 0x00 on a read of offsets 0, 2, 3, 4, 6 and 7, and whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Register offset within the window |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| in_lines | input | 16 | Asynchronous input channel levels |
| out_lines | output | 16 | Output channel drive |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bound checker checks on every cycle the bus-side rules that hold without regard to history. These are: output bytes that follow their writes (R2), output lines that hold without a write (R8), `irq` low right after a disabling write (R4), `irq` that stays high until it is cleared (R5), and zero data on unmapped reads (R10). Only the bench scenarios can show the behaviours that depend on input timing: the synchronizer latency on reads (R3), interrupt latency for rising and falling edges (R5), ignored changes while disabled (R7), and a clear that collides with a new edge (R9).

// File: rtl/iso_dio_pkg.sv
// Package: shared widths, offsets and types for the isolated digital I/O
// register block. Assumes a byte-wide bus and an 8-entry offset window.
package iso_dio_pkg;
    localparam int DW     = 8;            // bus data width
    localparam int AW     = 3;            // offset width
    localparam int NBYTES = 2;            // byte lanes per direction
    localparam int LINES  = DW * NBYTES;  // channels per direction

    typedef logic [AW-1:0] ofs_t;

    // Offsets that the host software relies on
    localparam ofs_t OFS_OUT_LO = 3'd0;
    localparam ofs_t OFS_IN_LO  = 3'd1;
    localparam ofs_t OFS_CTL    = 3'd2;
    localparam ofs_t OFS_OUT_HI = 3'd4;
    localparam ofs_t OFS_IN_HI  = 3'd5;
endpackage

// File: rtl/iso_dio_sync.sv
// Module: multi-stage synchronizer with change detection.
// Brings W asynchronous lines into the clk domain through STAGES flops and
// flags any line whose synchronized level differs from the previous sample.
// Assumes STAGES >= 2. Reset clears all stages to zero.
module iso_dio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic         any_change
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    // Purpose: shift the inputs through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    // Purpose: keep the previous synchronized sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign sync_out   = stage_q[STAGES-1];
    assign any_change = |(stage_q[STAGES-1] ^ prev_q);
endmodule

// File: rtl/iso_dio_outreg.sv
// Module: byte-lane output registers.
// Each lane loads the write data when its load enable is high and holds
// otherwise. The lanes cannot be read back. Reset drives every line low.
module iso_dio_outreg #(
    parameter int DW     = 8,
    parameter int NBYTES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NBYTES-1:0]    load,
    input  logic [DW-1:0]        wdata,
    output logic [DW*NBYTES-1:0] lines
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [DW-1:0] lane_q;

        // Purpose: load or hold one byte lane
        always_ff @(posedge clk) begin
            if (!rst_n)       lane_q <= '0;
            else if (load[b]) lane_q <= wdata;
        end

        assign lines[b*DW +: DW] = lane_q;
    end
endmodule

// File: rtl/iso_dio_irq.sv
// Module: interrupt enable and pending state.
// Enable comes from read side effects and disable from write side effects.
// Disable wins and also drops the pending flag. A new change outranks an
// acknowledge in the same cycle. Assumes one-cycle strobes.
module iso_dio_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,     // read of the control offset
    input  logic dis_req,    // write to the control offset
    input  logic ack_req,    // write to the low input offset
    input  logic change,     // synchronized input change this cycle
    output logic irq
);
    logic en_q;
    logic pend_q;

    // Purpose: track whether the interrupt is enabled
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (dis_req) en_q <= 1'b0;
        else if (en_req)  en_q <= 1'b1;
    end

    // Purpose: record change events while enabled, clear on ack or disable
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (dis_req)          pend_q <= 1'b0;
        else if (en_q && change)   pend_q <= 1'b1;
        else if (ack_req)          pend_q <= 1'b0;
    end

    assign irq = pend_q & en_q;
endmodule

// File: rtl/iso_dio_regs.sv
// Module: top of the isolated digital I/O register block.
// Decodes the 3-bit offset into register accesses and side effects, drives
// the output lanes, returns synchronized input bytes and raises an interrupt
// on any input change. Assumes strobes are single-cycle and synchronous.
module iso_dio_regs
    import iso_dio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [LINES-1:0] in_lines,
    output logic [LINES-1:0] out_lines,
    output logic             irq
);
    logic [NBYTES-1:0] lane_load;
    logic [LINES-1:0]  in_sync;
    logic              in_change;

    // Purpose: decode writes to the output lanes
    always_comb begin
        lane_load    = '0;
        lane_load[0] = bus_wr && (bus_addr == OFS_OUT_LO);
        lane_load[1] = bus_wr && (bus_addr == OFS_OUT_HI);
    end

    iso_dio_outreg #(.DW(DW), .NBYTES(NBYTES)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (lane_load),
        .wdata (bus_wdata),
        .lines (out_lines)
    );

    iso_dio_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (in_lines),
        .sync_out   (in_sync),
        .any_change (in_change)
    );

    iso_dio_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_req  (bus_rd && (bus_addr == OFS_CTL)),
        .dis_req (bus_wr && (bus_addr == OFS_CTL)),
        .ack_req (bus_wr && (bus_addr == OFS_IN_LO)),
        .change  (in_change),
        .irq     (irq)
    );

    // Purpose: return input bytes on mapped reads, zero elsewhere
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_IN_LO: bus_rdata = in_sync[DW-1:0];
                OFS_IN_HI: bus_rdata = in_sync[2*DW-1:DW];
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/iso_dio_regs_chk.sv
// Module: property checker bound to the register block's ports.
module iso_dio_regs_chk
    import iso_dio_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [DW-1:0]    bus_wdata,
    input logic [DW-1:0]    bus_rdata,
    input logic [LINES-1:0] in_lines,
    input logic [LINES-1:0] out_lines,
    input logic             irq
);
    assert_low_lane_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_OUT_LO) |=> (out_lines[7:0] == $past(bus_wdata)));

    assert_high_lane_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_OUT_HI) |=> (out_lines[15:8] == $past(bus_wdata)));

    assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == OFS_OUT_LO || bus_addr == OFS_OUT_HI))
        |=> $stable(out_lines));

    assert_disable_drops_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTL) |=> !irq);

    assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_wr && (bus_addr == OFS_CTL || bus_addr == OFS_IN_LO))) |=> irq);

    assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && (bus_addr == OFS_IN_LO || bus_addr == OFS_IN_HI)) |-> (bus_rdata == '0));
endmodule

bind iso_dio_regs iso_dio_regs_chk u_chk (.*);

// File: tb/iso_dio_regs_test.sv
module iso_dio_regs_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] in_lines = '0;
    logic [15:0] out_lines;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iso_dio_regs uut (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 out_lines", out_lines, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_outputs();
        bus_write(3'd0, 8'hA5);
        check("R2 low lane", out_lines, 16'h00A5);
        bus_write(3'd4, 8'h3C);
        check("R2 high lane", out_lines, 16'h3CA5);
        bus_write(3'd0, 8'h0F);
        check("R2 low rewrite keeps high", out_lines, 16'h3C0F);
    endtask

    task automatic t_inputs();
        logic [7:0] d;
        @(negedge clk);
        in_lines = 16'h5A96;
        @(posedge clk);
        bus_read(3'd1, d);   // read strobe at negedge after one edge: not yet synced
        check("R3 low byte before sync", {8'd0, d}, 16'h0000);
        bus_read(3'd1, d);
        check("R3 low byte", {8'd0, d}, 16'h0096);
        bus_read(3'd5, d);
        check("R3 high byte", {8'd0, d}, 16'h005A);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        bus_read(3'd0, d); check("R10 read ofs0", {8'd0, d}, 16'h0);
        bus_read(3'd3, d); check("R10 read ofs3", {8'd0, d}, 16'h0);
        bus_read(3'd4, d); check("R10 read ofs4", {8'd0, d}, 16'h0);
        bus_read(3'd7, d); check("R10 read ofs7", {8'd0, d}, 16'h0);
        bus_write(3'd2, 8'h00); // leave the interrupt disabled (R4)
        check("R10 idle rdata", {8'd0, bus_rdata}, 16'h0);
    endtask

    task automatic t_edges();
        logic [7:0] d;
        bus_read(3'd2, d);              // enable (R4)
        check("R10 read ctl", {8'd0, d}, 16'h0);
        @(negedge clk);
        in_lines[3] = ~in_lines[3];     // rising or falling
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R5 not before third edge", {15'd0, irq}, 16'd0);
        @(posedge clk); @(negedge clk);
        check("R5 irq on change", {15'd0, irq}, 16'd1);
        settle(3);
        check("R5 irq held", {15'd0, irq}, 16'd1);
        bus_write(3'd1, 8'h55);
        check("R6 ack clears", {15'd0, irq}, 16'd0);
        @(negedge clk);
        in_lines[12] = 1'b0;            // falling edge (bit was 1)
        settle(4);
        check("R5 falling edge", {15'd0, irq}, 16'd1);
        bus_write(3'd2, 8'hFF);
        check("R4 disable drops irq", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        @(negedge clk);
        in_lines[0] = ~in_lines[0];
        settle(5);
        bus_read(3'd2, d);
        settle(4);
        check("R7 stale change ignored", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_no_effect();
        logic [7:0] d;
        @(negedge clk);
        in_lines[8] = ~in_lines[8];
        settle(4);
        check("R8 irq raised for test", {15'd0, irq}, 16'd1);
        bus_write(3'd3, 8'hFF);
        bus_write(3'd5, 8'hFF);
        bus_write(3'd6, 8'hFF);
        bus_write(3'd7, 8'hFF);
        bus_read(3'd0, d);
        bus_read(3'd3, d);
        bus_read(3'd4, d);
        check("R8 outputs unchanged", out_lines, 16'h3C0F);
        check("R8 irq unchanged", {15'd0, irq}, 16'd1);
        bus_write(3'd1, 8'h00);
        check("R6 ack any value", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_collision();
        @(negedge clk);
        in_lines[15] = ~in_lines[15];
        @(posedge clk); @(posedge clk);
        bus_write(3'd1, 8'h00);         // ack lands on the detecting edge
        check("R9 collision keeps pending", {15'd0, irq}, 16'd1);
        bus_write(3'd1, 8'h00);
        check("R9 later ack clears", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_both_strobes();
        @(negedge clk);
        bus_addr = 3'd2; bus_rd = 1'b1; bus_wr = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        in_lines[1] = ~in_lines[1];
        settle(4);
        check("R4 write wins over read", {15'd0, irq}, 16'd0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        in_lines = 16'h1000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_outputs();
        t_inputs();
        t_unmapped();
        t_edges();
        t_disabled();
        t_no_effect();
        t_collision();
        t_both_strobes();
        finish_run();
    end
endmodule